// File: doc/BRIEF.md
# Pipe Cell Selector by Address Range

This block sits after frequency de-interleaving and sees the data cells of one frame in order. It tracks a running cell address and forwards only those cells that fall inside the address range of one of up to four pipes that have been picked for decoding. Every other cell is discarded. Address zero is the first data cell after the signalling cells.

Each pipe lane has a start address, a count of coded blocks and an enable. A single cells-per-block value is shared by all lanes. The range of a lane starts at its start address and has a length of the block count times the cells-per-block value. The end of the range is exclusive. The pipes do not have to be packed back to back. Cells that lie between ranges, whatever they carry, are dropped.

Ranges are latched when the frame marker arrives. A forwarded cell appears one register stage later, together with the index of the lane it matched.

Top module: `plp_cell_extractor`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` and `out_frame_start` are 0.
- R2: An input cell at address a is forwarded unchanged on the following cycle when an enabled lane k has start ≤ a < start + blocks × cells_per_block. `out_tag` then holds k as a binary number, and lane k uses bits [k*ADDR_W +: ADDR_W] of `cfg_start` and bits [k*BLK_W +: BLK_W] of `cfg_blocks`.
- R3: A cell whose address is in no active range, including one in a gap between ranges, is not forwarded. When `in_valid` is low, `out_valid` is low on the next cycle.
- R4: The range end is exclusive. The address start + blocks × cells_per_block is not forwarded for that lane, and the address one below it is forwarded.
- R5: When ranges overlap, the lane with the lowest index supplies the tag. The cell is forwarded exactly once.
- R6: A lane whose block count is zero, or whose `cfg_enable` bit is 0, matches no cell.
- R7: The address counter advances only on cycles with `in_valid` high. A `frame_start` cycle gives its own cell, if any, address 0.
- R8: Configuration inputs are captured only on a `frame_start` cycle, and that cycle already uses the new values. Changes made between markers have no effect until the next marker.
- R9: `out_frame_start` equals `frame_start` delayed by exactly one cycle.
- R10: After reset, no cell is forwarded until the first `frame_start`, because all lanes start disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame marker: clears address and captures configuration |
| in_valid | input | 1 | Input cell strobe |
| in_data | input | DATA_W | Input cell value |
| cfg_cells_per_block | input | CPB_W | Cells in one coded block, shared by all lanes |
| cfg_enable | input | NUM_SEL | Per-lane enable |
| cfg_start | input | NUM_SEL*ADDR_W | Per-lane start address, packed by lane |
| cfg_blocks | input | NUM_SEL*BLK_W | Per-lane block count, packed by lane |
| out_valid | output | 1 | Forwarded cell strobe |
| out_data | output | DATA_W | Forwarded cell value |
| out_tag | output | TAG_W | Index of the matching lane |
| out_frame_start | output | 1 | Frame marker delayed one cycle |

## Verification
The assertions take `frame_start` to be a single-cycle pulse. They also assume that no frame carries more than 2^ADDR_W cells, so the address counter never wraps inside a frame. The bench asserts the marker for exactly one cycle per frame and keeps every frame to a few dozen cells. Its ranges stay far below the counter limit, so the sum of start and length never overflows the end-address width. It also alters the configuration in the middle of a frame, which the design must tolerate because capture happens only at the marker.

// File: rtl/plp_xtr_pkg.sv
package plp_xtr_pkg;

    // Default sizing shared by the extractor and its helpers
    localparam int DEF_NUM_SEL = 4;
    localparam int DEF_ADDR_W  = 20;
    localparam int DEF_BLK_W   = 8;
    localparam int DEF_CPB_W   = 12;
    localparam int DEF_DATA_W  = 16;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int tag_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/plp_range_calc.sv
// Turns start/blocks/cells-per-block into an exclusive end address per lane
module plp_range_calc #(
    parameter int NUM_SEL = 4,
    parameter int ADDR_W  = 20,
    parameter int BLK_W   = 8,
    parameter int CPB_W   = 12,
    parameter int END_W   = 21
) (
    input  logic [NUM_SEL*ADDR_W-1:0] start_flat,
    input  logic [NUM_SEL*BLK_W-1:0]  blocks_flat,
    input  logic [NUM_SEL-1:0]        enable,
    input  logic [CPB_W-1:0]          cells_per_block,
    output logic [NUM_SEL*END_W-1:0]  end_flat,
    output logic [NUM_SEL-1:0]        live
);
    localparam int PROD_W = BLK_W + CPB_W;

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_lane
        logic [PROD_W-1:0] span;
        logic [BLK_W-1:0]  blk;
        always_comb begin
            blk  = blocks_flat[g*BLK_W +: BLK_W];
            span = PROD_W'(blk) * PROD_W'(cells_per_block);
            end_flat[g*END_W +: END_W] = END_W'(start_flat[g*ADDR_W +: ADDR_W])
                                       + END_W'(span);
            // zero blocks or disabled lane never matches
            live[g] = enable[g] && (blk != '0);
        end
    end

endmodule

// File: rtl/plp_range_match.sv
// Per-lane window compare of the current cell address
module plp_range_match #(
    parameter int NUM_SEL = 4,
    parameter int ADDR_W  = 20,
    parameter int END_W   = 21
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_SEL*ADDR_W-1:0] start_flat,
    input  logic [NUM_SEL*END_W-1:0]  end_flat,
    input  logic [NUM_SEL-1:0]        live,
    output logic [NUM_SEL-1:0]        hit
);
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_cmp
        logic ge_start;
        logic lt_end;
        always_comb begin
            ge_start = addr >= start_flat[g*ADDR_W +: ADDR_W];
            lt_end   = END_W'(addr) < end_flat[g*END_W +: END_W];
            hit[g]   = live[g] && ge_start && lt_end;
        end
    end

endmodule

// File: rtl/plp_prio_pick.sv
// Lowest set index wins
module plp_prio_pick #(
    parameter int NUM_SEL = 4,
    parameter int TAG_W   = 2
) (
    input  logic [NUM_SEL-1:0] hit,
    output logic               any,
    output logic [TAG_W-1:0]   idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM_SEL - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any = 1'b1;
                idx = TAG_W'(i);
            end
        end
    end

endmodule

// File: rtl/plp_cell_extractor.sv
module plp_cell_extractor
    import plp_xtr_pkg::*;
#(
    parameter int NUM_SEL = DEF_NUM_SEL,
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int BLK_W   = DEF_BLK_W,
    parameter int CPB_W   = DEF_CPB_W,
    parameter int DATA_W  = DEF_DATA_W,
    localparam int TAG_W  = tag_width(NUM_SEL)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         in_data,
    input  logic [CPB_W-1:0]          cfg_cells_per_block,
    input  logic [NUM_SEL-1:0]        cfg_enable,
    input  logic [NUM_SEL*ADDR_W-1:0] cfg_start,
    input  logic [NUM_SEL*BLK_W-1:0]  cfg_blocks,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_data,
    output logic [TAG_W-1:0]          out_tag,
    output logic                      out_frame_start
);
    localparam int END_W = max_int(ADDR_W, BLK_W + CPB_W) + 1;

    typedef struct packed {
        logic [ADDR_W-1:0]         cnt;
        logic [NUM_SEL*ADDR_W-1:0] start;
        logic [NUM_SEL*END_W-1:0]  stop;
        logic [NUM_SEL-1:0]        live;
        logic                      vld;
        logic [DATA_W-1:0]         data;
        logic [TAG_W-1:0]          tag;
        logic                      fs;
    } state_t;

    state_t st_d, st_q;

    // Freshly computed ranges from the configuration inputs
    logic [NUM_SEL*END_W-1:0] new_stop;
    logic [NUM_SEL-1:0]       new_live;

    plp_range_calc #(
        .NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W), .BLK_W(BLK_W),
        .CPB_W(CPB_W), .END_W(END_W)
    ) u_calc (
        .start_flat      (cfg_start),
        .blocks_flat     (cfg_blocks),
        .enable          (cfg_enable),
        .cells_per_block (cfg_cells_per_block),
        .end_flat        (new_stop),
        .live            (new_live)
    );

    // Ranges in force this cycle: the marker cycle already uses new ones
    logic [ADDR_W-1:0]         cur_addr;
    logic [NUM_SEL*ADDR_W-1:0] eff_start;
    logic [NUM_SEL*END_W-1:0]  eff_stop;
    logic [NUM_SEL-1:0]        eff_live;

    always_comb begin
        if (frame_start) begin
            cur_addr  = '0;
            eff_start = cfg_start;
            eff_stop  = new_stop;
            eff_live  = new_live;
        end else begin
            cur_addr  = st_q.cnt;
            eff_start = st_q.start;
            eff_stop  = st_q.stop;
            eff_live  = st_q.live;
        end
    end

    logic [NUM_SEL-1:0] hit;
    logic               hit_any;
    logic [TAG_W-1:0]   hit_idx;

    plp_range_match #(
        .NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W), .END_W(END_W)
    ) u_match (
        .addr       (cur_addr),
        .start_flat (eff_start),
        .end_flat   (eff_stop),
        .live       (eff_live),
        .hit        (hit)
    );

    plp_prio_pick #(
        .NUM_SEL(NUM_SEL), .TAG_W(TAG_W)
    ) u_pick (
        .hit (hit),
        .any (hit_any),
        .idx (hit_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = eff_start;
        st_d.stop  = eff_stop;
        st_d.live  = eff_live;
        st_d.cnt   = in_valid ? cur_addr + ADDR_W'(1) : cur_addr;
        st_d.vld   = in_valid && hit_any;
        st_d.fs    = frame_start;
        if (in_valid && hit_any) begin
            st_d.data = in_data;
            st_d.tag  = hit_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid       = st_q.vld;
    assign out_data        = st_q.data;
    assign out_tag         = st_q.tag;
    assign out_frame_start = st_q.fs;

endmodule

// File: rtl/plp_cell_extractor_chk.sv
module plp_cell_extractor_chk #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [TAG_W-1:0]  out_tag,
    input logic              out_frame_start
);
    logic seen_fs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_fs_q <= 1'b0;
        else if (frame_start) seen_fs_q <= 1'b1;
    end

    assert_fs_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> out_frame_start);

    assert_fs_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> !out_frame_start);

    assert_no_cell_no_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_data_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_valid || out_data == $past(in_data)));

    assert_gate_before_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seen_fs_q);

    assert_tag_stable_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_tag));

endmodule

bind plp_cell_extractor plp_cell_extractor_chk #(
    .DATA_W(DATA_W), .TAG_W(TAG_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .frame_start     (frame_start),
    .in_valid        (in_valid),
    .in_data         (in_data),
    .out_valid       (out_valid),
    .out_data        (out_data),
    .out_tag         (out_tag),
    .out_frame_start (out_frame_start)
);

// File: tb/plp_cell_extractor_tb.sv
`timescale 1ns/1ps
module plp_cell_extractor_tb;
    localparam int NUM_SEL = 4;
    localparam int ADDR_W  = 20;
    localparam int BLK_W   = 8;
    localparam int CPB_W   = 12;
    localparam int DATA_W  = 16;
    localparam int TAG_W   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic [CPB_W-1:0] cfg_cells_per_block = '0;
    logic [NUM_SEL-1:0] cfg_enable = '0;
    logic [NUM_SEL*ADDR_W-1:0] cfg_start = '0;
    logic [NUM_SEL*BLK_W-1:0] cfg_blocks = '0;
    logic out_valid;
    logic [DATA_W-1:0] out_data;
    logic [TAG_W-1:0] out_tag;
    logic out_frame_start;

    always #10 clk = ~clk;   // 50 MHz

    plp_cell_extractor #(
        .NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W), .BLK_W(BLK_W),
        .CPB_W(CPB_W), .DATA_W(DATA_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .in_valid(in_valid), .in_data(in_data),
        .cfg_cells_per_block(cfg_cells_per_block), .cfg_enable(cfg_enable),
        .cfg_start(cfg_start), .cfg_blocks(cfg_blocks),
        .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag),
        .out_frame_start(out_frame_start)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Scoreboard queues
    logic [DATA_W-1:0] q_data[$];
    logic [TAG_W-1:0]  q_tag[$];
    string             q_req[$];

    // Reference model state, taken from the requirements
    int m_cnt = 0;
    int m_start[NUM_SEL];
    int m_end[NUM_SEL];
    bit m_live[NUM_SEL];
    logic [DATA_W-1:0] seq = 16'h1000;

    initial begin
        for (int i = 0; i < NUM_SEL; i++) begin
            m_start[i] = 0; m_end[i] = 0; m_live[i] = 0;
        end
    end

    task automatic set_lane(input int k, input bit en, input int st, input int blk);
        cfg_enable[k] = en;
        cfg_start[k*ADDR_W +: ADDR_W] = ADDR_W'(st);
        cfg_blocks[k*BLK_W +: BLK_W] = BLK_W'(blk);
    endtask

    // Drive one cycle and update the model
    task automatic cyc(input bit fs, input bit v);
        int addr;
        int win;
        int nhit;
        @(posedge clk); #1;
        frame_start = fs;
        in_valid = v;
        in_data = seq;
        if (fs) begin  // R8: capture only at marker
            for (int k = 0; k < NUM_SEL; k++) begin
                m_start[k] = int'(cfg_start[k*ADDR_W +: ADDR_W]);
                m_end[k] = m_start[k] + int'(cfg_blocks[k*BLK_W +: BLK_W]) * int'(cfg_cells_per_block);
                m_live[k] = cfg_enable[k] && (cfg_blocks[k*BLK_W +: BLK_W] != 0);  // R6
            end
        end
        addr = fs ? 0 : m_cnt;   // R7
        if (v) begin
            win = -1; nhit = 0;
            for (int k = NUM_SEL - 1; k >= 0; k--) begin
                if (m_live[k] && addr >= m_start[k] && addr < m_end[k]) begin
                    win = k; nhit++;
                end
            end
            if (win >= 0) begin
                q_data.push_back(seq);
                q_tag.push_back(TAG_W'(win));
                if (nhit > 1) q_req.push_back("R5");
                else if (addr == m_end[win] - 1) q_req.push_back("R4");
                else q_req.push_back("R2");
            end
            m_cnt = addr + 1;
            seq = seq + 1;
        end else begin
            m_cnt = addr;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0);
    endtask

    task automatic cells(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1);
    endtask

    // Monitor: R9 marker delay and scoreboard compare
    logic fs_seen = 1'b0;
    always @(posedge clk) fs_seen <= rst_n ? frame_start : 1'b0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (out_frame_start !== fs_seen) begin
                failures++;
                $display("FAIL R9 out_frame_start act=%0b exp=%0b", out_frame_start, fs_seen);
            end
            if (out_valid === 1'b1) begin
                checks++;
                if (q_data.size() == 0) begin
                    failures++;
                    $display("FAIL R3 unexpected cell act=%h exp=none", out_data);
                end else begin
                    logic [DATA_W-1:0] ed;
                    logic [TAG_W-1:0] et;
                    string er;
                    ed = q_data.pop_front();
                    et = q_tag.pop_front();
                    er = q_req.pop_front();
                    if (out_data !== ed || out_tag !== et) begin
                        failures++;
                        $display("FAIL %s cell act=%h/%0d exp=%h/%0d", er, out_data, out_tag, ed, et);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_frame_start !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset outputs act=%0b%0b exp=00", out_valid, out_frame_start);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 after reset act=%0b exp=0", out_valid);
        end

        // R10: configuration present but no marker yet -> nothing forwarded
        cfg_cells_per_block = 4;
        set_lane(0, 1, 0, 2);    // 0..7
        set_lane(1, 1, 10, 1);   // 10..13, gap 8..9 (R3)
        set_lane(2, 1, 20, 0);   // zero blocks (R6)
        set_lane(3, 0, 14, 2);   // disabled (R6)
        cells(6);
        idle(2);

        // Frame A: marker with a cell at address 0 (R7), gaps in valid
        cyc(1, 1);
        cells(5);
        idle(2);
        cells(10);               // reaches 10..13, crosses end 14 (R4)
        cyc(0, 0);
        cells(12);
        idle(3);

        // Frame B: overlaps, marker without a cell (R5, R7)
        set_lane(0, 1, 8, 1);    // 8..11
        set_lane(1, 1, 4, 3);    // 4..15
        set_lane(2, 1, 0, 5);    // 0..19
        set_lane(3, 1, 30, 1);   // 30..33
        cyc(1, 0);
        cells(12);
        // R8: change mid-frame, must not take effect before next marker
        cfg_cells_per_block = 3;
        set_lane(0, 1, 2, 2);    // next frame: 2..7
        set_lane(1, 0, 0, 4);
        set_lane(2, 1, 9, 1);    // next frame: 9..11
        set_lane(3, 1, 15, 0);
        cells(24);
        idle(3);

        // Frame C: new configuration applies from marker cell
        cyc(1, 1);
        cells(15);
        idle(4);

        checks++;
        if (q_data.size() != 0) begin
            failures++;
            $display("FAIL R2 missing cells act=%0d exp=0", q_data.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule